// File: doc/BRIEF.md
# Configurable Clocked Serial Channel

This block is one synchronous serial channel with three wires: a clock, a data input and a data output. As clock master it makes the serial clock itself. The bit rate comes from a power-of-two prescaler followed by a programmable half-period divider. As slave it follows a clock from outside. That clock is brought into the system domain through a two-stage synchroniser, and its edges are found there.

The host loads words into a one-entry transmit buffer and collects words from a one-entry receive buffer. Static configuration inputs set the frame length (7 to 16 bits), the bit order, the clock idle level, the clock phase, the data inversion and the interrupt mode. A single interrupt pulse marks either the end of each frame or the moment the transmit buffer hands its word to the shifter. A sticky overrun flag records a received word that was overwritten before the host collected it.

Top module: `sio_channel`

## Requirements
- R1: The frame length is `cfg_frame_len` clamped into the range 7..16. A value below 7 gives 7 bits and a value above 16 gives 16 bits. In master mode a frame produces exactly that many leading clock edges.
- R2: With `cfg_lsb_first`=0 the word goes out most significant bit first: wire bit k is data[len-1-k]. With `cfg_lsb_first`=1 wire bit k is data[k]. Received bits are placed back into the word in the same order.
- R3: With `cfg_invert`=1 every bit driven on `sdo` is the complement of the data bit, and every bit sampled on `sdi` is complemented before it is stored.
- R4: The clock idles at `cfg_cpol`. The leading edge leaves that level. With `cfg_cpha`=0 data is sampled on leading edges and changes on trailing edges. With `cfg_cpha`=1 data changes on leading edges and is sampled on trailing edges.
- R5: In master mode (`cfg_master`=1, `sck_oe`=1) successive leading edges are 2*(`cfg_div`+1)*2^`cfg_presc` system clocks apart. Between frames `sck_out` rests at `cfg_cpol`.
- R6: In slave mode (`cfg_master`=0) `sck_oe` is 0. Bits are shifted and sampled on edges of `sck_in`, which are seen after synchronisation.
- R7: At the end of a frame the received word appears on `rx_data` and `rx_valid` rises in the same cycle. `rx_valid` stays set until `rx_rd` is asserted.
- R8: `ovr_flag` is set when a frame ends while `rx_valid` is still set and not being read. In that case the new word replaces the old one. The flag stays set until `ovr_clr` is pulsed.
- R9: `irq` is a one-cycle pulse. With `cfg_irq_on_empty`=0 it comes in the cycle `rx_valid` is set for a frame. With `cfg_irq_on_empty`=1 it comes in the cycle `tx_empty` rises because the buffered word moved into the shifter.
- R10: `tx_empty` is 1 when the transmit buffer can accept a word. A `tx_wr` while `tx_empty` is 0 is ignored, so that word is never sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_master | input | 1 | 1 = drive the clock, 0 = follow `sck_in` |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | 0 = sample on leading edge, 1 = sample on trailing edge |
| cfg_lsb_first | input | 1 | Bit order select |
| cfg_invert | input | 1 | Complement transmitted and received data |
| cfg_irq_on_empty | input | 1 | Interrupt on buffer hand-off instead of frame end |
| cfg_frame_len | input | LEN_W (5) | Requested frame length, clamped to 7..16 |
| cfg_presc | input | PRESC_W (4) | Prescaler exponent, divides by 2^value |
| cfg_div | input | DIV_W (8) | Half-period count minus one, in prescaled ticks |
| tx_data | input | MAX_LEN (16) | Word to transmit, right-aligned |
| tx_wr | input | 1 | Write `tx_data` into the transmit buffer |
| tx_empty | output | 1 | Transmit buffer free |
| rx_data | output | MAX_LEN (16) | Last received word, right-aligned |
| rx_valid | output | 1 | Unread word in `rx_data` |
| rx_rd | input | 1 | Acknowledge `rx_data` |
| ovr_flag | output | 1 | Sticky overrun |
| ovr_clr | input | 1 | Clear `ovr_flag` |
| irq | output | 1 | Interrupt pulse |
| sck_in | input | 1 | External serial clock (slave) |
| sck_out | output | 1 | Generated serial clock (master) |
| sck_oe | output | 1 | Output enable for the serial clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |

## Verification
A wrong bit counter shows on the wire within one frame: the number of leading edges differs, or `rx_valid` rises early or late. A wrong shift index or order select scrambles the `sdo` sequence from the first bit on, and a bench that records the wire bit by bit against the requirement can see it. Faults in the buffer flags only show up across frames. A lost hand-off, a second send of a dropped write, or an overrun flag that clears itself appears one frame later, so the scenarios run several frames back to back and keep watching afterwards.

// File: rtl/sio_pkg.sv
package sio_pkg;
    typedef struct packed {
        logic lead;
        logic trail;
    } sio_edge_t;
endpackage

// File: rtl/sio_master_clk.sv
module sio_master_clk
    import sio_pkg::*;
#(
    parameter int PRESC_W = 4,
    parameter int DIV_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [PRESC_W-1:0] presc_exp,
    input  logic [DIV_W-1:0]   div,
    input  logic               cpol,
    output sio_edge_t          ev,
    output logic               sck
);
    localparam int PCNT_W = (1 << PRESC_W) - 1;

    typedef struct packed {
        logic [PCNT_W-1:0] pcnt;
        logic [DIV_W-1:0]  hcnt;
        logic              phase;
    } mclk_t;

    mclk_t q, d;
    logic [PCNT_W-1:0] mask;
    logic              tick;

    always_comb begin
        d    = q;
        ev   = '0;
        mask = ~({PCNT_W{1'b1}} << presc_exp);
        tick = (q.pcnt == mask);
        if (!run) begin
            d = '0;
        end else begin
            d.pcnt = tick ? '0 : q.pcnt + 1'b1;
            if (tick) begin
                if (q.hcnt == div) begin
                    d.hcnt  = '0;
                    d.phase = ~q.phase;
                    ev.lead  = ~q.phase;
                    ev.trail = q.phase;
                end else begin
                    d.hcnt = q.hcnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sck = cpol ^ q.phase;
endmodule

// File: rtl/sio_slave_sync.sv
module sio_slave_sync
    import sio_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sck_in,
    input  logic      cpol,
    output sio_edge_t ev
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t q, d;
    logic  lvl_now, lvl_old;

    always_comb begin
        d.s1 = sck_in;
        d.s2 = q.s1;
        d.s3 = q.s2;
        lvl_now  = q.s2 ^ cpol;
        lvl_old  = q.s3 ^ cpol;
        ev.lead  = lvl_now & ~lvl_old;
        ev.trail = ~lvl_now & lvl_old;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/sio_shift_engine.sv
module sio_shift_engine
    import sio_pkg::*;
#(
    parameter int MAX_LEN = 16,
    parameter int MIN_LEN = 7,
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  sio_edge_t          ev,
    input  logic [LEN_W-1:0]   cfg_len,
    input  logic               lsb_first,
    input  logic               invert,
    input  logic               cpha,
    input  logic               irq_on_empty,
    input  logic [MAX_LEN-1:0] tx_data,
    input  logic               tx_wr,
    input  logic               rx_rd,
    input  logic               ovr_clr,
    input  logic               sdi,
    output logic               busy,
    output logic               sdo,
    output logic               tx_empty,
    output logic [MAX_LEN-1:0] rx_data,
    output logic               rx_valid,
    output logic               ovr,
    output logic               irq
);
    typedef struct packed {
        logic [MAX_LEN-1:0] txbuf;
        logic               txfull;
        logic [MAX_LEN-1:0] word;
        logic               busy;
        logic [LEN_W-1:0]   cnt;
        logic               sdo;
        logic [MAX_LEN-1:0] rsh;
        logic [MAX_LEN-1:0] rxbuf;
        logic               rxvalid;
        logic               ovr;
        logic               irq;
    } eng_t;

    eng_t q, d;
    logic [LEN_W-1:0]   len;
    logic               rx_bit;
    logic [MAX_LEN-1:0] rsh_n;

    function automatic logic pick_bit(input logic [MAX_LEN-1:0] w,
                                      input logic [LEN_W-1:0]   idx,
                                      input logic [LEN_W-1:0]   flen,
                                      input logic               lsb);
        logic [LEN_W-1:0]   pos;
        logic [MAX_LEN-1:0] t;
        pos = lsb ? idx : (flen - LEN_W'(1) - idx);
        t   = w >> pos;
        return t[0];
    endfunction

    always_comb begin
        d      = q;
        d.irq  = 1'b0;
        rsh_n  = q.rsh;
        rx_bit = sdi ^ invert;

        if (cfg_len < LEN_W'(MIN_LEN))      len = LEN_W'(MIN_LEN);
        else if (cfg_len > LEN_W'(MAX_LEN)) len = LEN_W'(MAX_LEN);
        else                                len = cfg_len;

        if (rx_rd)   d.rxvalid = 1'b0;
        if (ovr_clr) d.ovr     = 1'b0;
        if (tx_wr && !q.txfull) begin
            d.txbuf  = tx_data;
            d.txfull = 1'b1;
        end

        if (!q.busy) begin
            if (q.txfull) begin
                d.word   = q.txbuf;
                d.txfull = 1'b0;
                d.busy   = 1'b1;
                d.cnt    = '0;
                d.rsh    = '0;
                d.sdo    = pick_bit(q.txbuf, '0, len, lsb_first) ^ invert;
                d.irq    = irq_on_empty;
            end
        end else begin
            if (ev.lead) begin
                if (!cpha) rsh_n = lsb_first ? {rx_bit, q.rsh[MAX_LEN-1:1]}
                                             : {q.rsh[MAX_LEN-2:0], rx_bit};
                else       d.sdo = pick_bit(q.word, q.cnt, len, lsb_first) ^ invert;
            end
            if (ev.trail) begin
                if (cpha) rsh_n = lsb_first ? {rx_bit, q.rsh[MAX_LEN-1:1]}
                                            : {q.rsh[MAX_LEN-2:0], rx_bit};
                if (q.cnt + LEN_W'(1) == len) begin
                    d.busy    = 1'b0;
                    d.rxbuf   = lsb_first ? (rsh_n >> (LEN_W'(MAX_LEN) - len)) : rsh_n;
                    d.rxvalid = 1'b1;
                    if (q.rxvalid && !rx_rd) d.ovr = 1'b1;
                    d.irq     = ~irq_on_empty;
                end else begin
                    d.cnt = q.cnt + LEN_W'(1);
                    if (!cpha) d.sdo = pick_bit(q.word, q.cnt + LEN_W'(1), len, lsb_first) ^ invert;
                end
            end
            d.rsh = rsh_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy     = q.busy;
    assign sdo      = q.sdo;
    assign tx_empty = ~q.txfull;
    assign rx_data  = q.rxbuf;
    assign rx_valid = q.rxvalid;
    assign ovr      = q.ovr;
    assign irq      = q.irq;
endmodule

// File: rtl/sio_channel.sv
module sio_channel
    import sio_pkg::*;
#(
    parameter int MAX_LEN = 16,
    parameter int MIN_LEN = 7,
    parameter int PRESC_W = 4,
    parameter int DIV_W   = 8,
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_master,
    input  logic               cfg_cpol,
    input  logic               cfg_cpha,
    input  logic               cfg_lsb_first,
    input  logic               cfg_invert,
    input  logic               cfg_irq_on_empty,
    input  logic [LEN_W-1:0]   cfg_frame_len,
    input  logic [PRESC_W-1:0] cfg_presc,
    input  logic [DIV_W-1:0]   cfg_div,
    input  logic [MAX_LEN-1:0] tx_data,
    input  logic               tx_wr,
    output logic               tx_empty,
    output logic [MAX_LEN-1:0] rx_data,
    output logic               rx_valid,
    input  logic               rx_rd,
    output logic               ovr_flag,
    input  logic               ovr_clr,
    output logic               irq,
    input  logic               sck_in,
    output logic               sck_out,
    output logic               sck_oe,
    input  logic               sdi,
    output logic               sdo
);
    sio_edge_t m_ev, s_ev, ev;
    logic      eng_busy;

    sio_master_clk #(.PRESC_W(PRESC_W), .DIV_W(DIV_W)) u_mclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (eng_busy & cfg_master),
        .presc_exp(cfg_presc),
        .div      (cfg_div),
        .cpol     (cfg_cpol),
        .ev       (m_ev),
        .sck      (sck_out)
    );

    sio_slave_sync u_ssync (
        .clk   (clk),
        .rst_n (rst_n),
        .sck_in(sck_in),
        .cpol  (cfg_cpol),
        .ev    (s_ev)
    );

    assign ev     = cfg_master ? m_ev : s_ev;
    assign sck_oe = cfg_master;

    sio_shift_engine #(.MAX_LEN(MAX_LEN), .MIN_LEN(MIN_LEN), .LEN_W(LEN_W)) u_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev          (ev),
        .cfg_len     (cfg_frame_len),
        .lsb_first   (cfg_lsb_first),
        .invert      (cfg_invert),
        .cpha        (cfg_cpha),
        .irq_on_empty(cfg_irq_on_empty),
        .tx_data     (tx_data),
        .tx_wr       (tx_wr),
        .rx_rd       (rx_rd),
        .ovr_clr     (ovr_clr),
        .sdi         (sdi),
        .busy        (eng_busy),
        .sdo         (sdo),
        .tx_empty    (tx_empty),
        .rx_data     (rx_data),
        .rx_valid    (rx_valid),
        .ovr         (ovr_flag),
        .irq         (irq)
    );
endmodule

// File: rtl/sio_channel_chk.sv
module sio_channel_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_master,
    input logic cfg_cpol,
    input logic eng_busy,
    input logic sck_out,
    input logic tx_empty,
    input logic rx_valid,
    input logic rx_rd,
    input logic ovr_flag,
    input logic ovr_clr,
    input logic irq
);
    // R5: clock rests at its idle level whenever no frame is running
    a_r5_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && !eng_busy) |-> (sck_out == cfg_cpol));

    // R7: an unread word stays flagged
    a_r7_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_rd) |=> rx_valid);

    // R8: overrun is sticky until cleared
    a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !ovr_clr) |=> ovr_flag);

    // R9: interrupt lasts one cycle
    a_r9_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R10: a buffered word is not taken while a frame is running
    a_r10_buf_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_empty && eng_busy) |=> !tx_empty);
endmodule

bind sio_channel sio_channel_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_master(cfg_master),
    .cfg_cpol  (cfg_cpol),
    .eng_busy  (eng_busy),
    .sck_out   (sck_out),
    .tx_empty  (tx_empty),
    .rx_valid  (rx_valid),
    .rx_rd     (rx_rd),
    .ovr_flag  (ovr_flag),
    .ovr_clr   (ovr_clr),
    .irq       (irq)
);

// File: tb/sio_channel_bench.sv
module sio_channel_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_master = 1'b1, cfg_cpol = 1'b0, cfg_cpha = 1'b0;
    logic        cfg_lsb_first = 1'b0, cfg_invert = 1'b0, cfg_irq_on_empty = 1'b0;
    logic [4:0]  cfg_frame_len = 5'd8;
    logic [3:0]  cfg_presc = '0;
    logic [7:0]  cfg_div = 8'd1;
    logic [15:0] tx_data = '0;
    logic        tx_wr = 1'b0, rx_rd = 1'b0, ovr_clr = 1'b0;
    logic        sck_in = 1'b0, sdi_drv = 1'b0, loopback = 1'b1;
    logic        tx_empty, rx_valid, ovr_flag, irq, sck_out, sck_oe, sdo, sdi;
    logic [15:0] rx_data;
    int          n_chk = 0, n_fail = 0;
    bit          done = 0;

    always #10 clk = ~clk;
    assign sdi = loopback ? sdo : sdi_drv;

    sio_channel u_sio_channel (
        .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_cpol(cfg_cpol),
        .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first), .cfg_invert(cfg_invert),
        .cfg_irq_on_empty(cfg_irq_on_empty), .cfg_frame_len(cfg_frame_len),
        .cfg_presc(cfg_presc), .cfg_div(cfg_div), .tx_data(tx_data), .tx_wr(tx_wr),
        .tx_empty(tx_empty), .rx_data(rx_data), .rx_valid(rx_valid), .rx_rd(rx_rd),
        .ovr_flag(ovr_flag), .ovr_clr(ovr_clr), .irq(irq), .sck_in(sck_in),
        .sck_out(sck_out), .sck_oe(sck_oe), .sdi(sdi), .sdo(sdo)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int clamp_len(input int l);
        return (l < 7) ? 7 : ((l > 16) ? 16 : l);
    endfunction

    function automatic logic [15:0] wire_seq(input logic [15:0] w, input int len,
                                            input bit lsb, input bit inv);
        logic [15:0] s = '0;
        for (int k = 0; k < len; k++) s[k] = (lsb ? w[k] : w[len-1-k]) ^ inv;
        return s;
    endfunction

    function automatic logic [15:0] seq_word(input logic [15:0] s, input int len,
                                            input bit lsb, input bit inv);
        logic [15:0] w = '0;
        for (int k = 0; k < len; k++) begin
            if (lsb) w[k] = s[k] ^ inv;
            else     w[len-1-k] = s[k] ^ inv;
        end
        return w;
    endfunction

    task automatic read_rx();
        @(negedge clk) rx_rd = 1'b1;
        @(negedge clk) rx_rd = 1'b0;
    endtask

    // Runs one master frame, recording the wire bits, edge counts and interrupts.
    task automatic master_xfer(input logic [15:0] data, input int len,
                               output logic [15:0] seq, output int nlead, output int period,
                               output int irqs, output bit irq_pos_ok, output bit idle_ok);
        int t = 0, first = -1, second = -1, k = 0, ntrail = 0;
        logic prev_sck, prev_empty;
        seq = '0; nlead = 0; irqs = 0; irq_pos_ok = 1; idle_ok = 1;
        @(negedge clk) begin tx_data = data; tx_wr = 1'b1; end
        @(negedge clk) tx_wr = 1'b0;
        prev_sck = sck_out; prev_empty = tx_empty;
        repeat (20000) begin
            @(negedge clk); t++;
            if (irq) irqs++;
            if (cfg_irq_on_empty && tx_empty && !prev_empty && !irq) irq_pos_ok = 0;
            if (sck_out != prev_sck) begin
                if (sck_out != cfg_cpol) begin
                    nlead++;
                    if (first < 0) first = t; else if (second < 0) second = t;
                end else ntrail++;
                if ((sck_out != cfg_cpol) == !cfg_cpha) begin
                    if (k < 16) seq[k] = sdo;
                    k++;
                end
            end
            prev_sck = sck_out; prev_empty = tx_empty;
            if (ntrail == len) begin
                if (!cfg_irq_on_empty && !(irq && rx_valid)) irq_pos_ok = 0;
                break;
            end
        end
        period = second - first;
        repeat (3) begin
            @(negedge clk);
            if (irq) irqs++;
            if (sck_out != cfg_cpol) idle_ok = 0;
        end
    endtask

    task automatic t_reset();
        chk(tx_empty == 1'b1, "R10 reset tx_empty", tx_empty, 1);
        chk(rx_valid == 1'b0, "R7 reset rx_valid", rx_valid, 0);
        chk(ovr_flag == 1'b0, "R8 reset ovr", ovr_flag, 0);
        chk(irq == 1'b0, "R9 reset irq", irq, 0);
        chk(sck_out == cfg_cpol, "R5 reset clock idle", sck_out, cfg_cpol);
    endtask

    task automatic t_master(input logic [15:0] data, input int req_len, input bit lsb,
                            input bit inv, input bit cpha, input bit cpol,
                            input int presc, input int div, input bit on_empty);
        logic [15:0] seq, mask;
        int nlead, period, irqs, len, exp_per;
        bit irq_ok, idle_ok;
        len = clamp_len(req_len);
        @(negedge clk);
        cfg_master = 1'b1; loopback = 1'b1;
        cfg_frame_len = 5'(req_len); cfg_lsb_first = lsb; cfg_invert = inv;
        cfg_cpha = cpha; cfg_cpol = cpol; cfg_presc = 4'(presc); cfg_div = 8'(div);
        cfg_irq_on_empty = on_empty;
        repeat (2) @(negedge clk);
        mask = 16'((32'd1 << len) - 1);
        master_xfer(data, len, seq, nlead, period, irqs, irq_ok, idle_ok);
        exp_per = 2 * (div + 1) * (1 << presc);
        chk(nlead == len, "R1 leading edge count", nlead, len);
        chk(seq == wire_seq(data & mask, len, lsb, inv), "R2/R3/R4 wire bits (R2 R3 R4)",
            seq, wire_seq(data & mask, len, lsb, inv));
        chk(period == exp_per, "R5 bit period", period, exp_per);
        chk(idle_ok, "R5 idle level after frame", sck_out, cpol);
        chk(sck_oe == 1'b1, "R5 sck_oe in master", sck_oe, 1);
        chk(rx_valid && rx_data == (data & mask), "R7 loopback word", rx_data, data & mask);
        chk(irqs == 1 && irq_ok, "R9 interrupt position", irqs, 1);
        read_rx();
        chk(rx_valid == 1'b0, "R7 rx_rd clears", rx_valid, 0);
    endtask

    task automatic t_overrun();
        logic [15:0] seq;
        int nlead, period, irqs;
        bit a, b;
        @(negedge clk);
        cfg_master = 1'b1; loopback = 1'b1; cfg_frame_len = 5'd8; cfg_lsb_first = 0;
        cfg_invert = 0; cfg_cpha = 0; cfg_cpol = 0; cfg_presc = 0; cfg_div = 8'd0;
        cfg_irq_on_empty = 0;
        master_xfer(16'h0C3, 8, seq, nlead, period, irqs, a, b);
        chk(ovr_flag == 1'b0, "R8 no overrun on first word", ovr_flag, 0);
        master_xfer(16'h05E, 8, seq, nlead, period, irqs, a, b);
        chk(ovr_flag == 1'b1, "R8 overrun set", ovr_flag, 1);
        chk(rx_data == 16'h05E, "R8 newer word kept", rx_data, 16'h05E);
        read_rx();
        repeat (3) @(negedge clk);
        chk(ovr_flag == 1'b1, "R8 overrun survives read", ovr_flag, 1);
        @(negedge clk) ovr_clr = 1'b1;
        @(negedge clk) ovr_clr = 1'b0;
        chk(ovr_flag == 1'b0, "R8 overrun cleared", ovr_flag, 0);
    endtask

    task automatic wait_rx(input int limit);
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (rx_valid) break;
        end
    endtask

    task automatic t_txbuf();
        @(negedge clk);
        cfg_master = 1'b1; loopback = 1'b1; cfg_frame_len = 5'd8; cfg_lsb_first = 0;
        cfg_invert = 0; cfg_cpha = 0; cfg_cpol = 0; cfg_presc = 0; cfg_div = 8'd3;
        cfg_irq_on_empty = 0;
        tx_data = 16'h11; tx_wr = 1'b1;
        @(negedge clk) tx_wr = 1'b0;
        @(negedge clk);
        chk(tx_empty == 1'b1, "R10 word handed to shifter", tx_empty, 1);
        tx_data = 16'h22; tx_wr = 1'b1;
        @(negedge clk) tx_data = 16'h33;
        @(negedge clk) tx_wr = 1'b0;
        chk(tx_empty == 1'b0, "R10 buffer full during frame", tx_empty, 0);
        wait_rx(500);
        chk(rx_valid && rx_data == 16'h11, "R10 first word", rx_data, 16'h11);
        read_rx();
        wait_rx(500);
        chk(rx_valid && rx_data == 16'h22, "R10 buffered word sent", rx_data, 16'h22);
        read_rx();
        wait_rx(300);
        chk(rx_valid == 1'b0, "R10 write while full ignored", rx_valid, 0);
        chk(tx_empty == 1'b1, "R10 buffer empty at end", tx_empty, 1);
    endtask

    task automatic t_slave(input logic [15:0] data, input logic [15:0] sin, input int len,
                           input bit lsb, input bit inv, input bit cpha, input bit cpol);
        logic [15:0] got = '0, mask, exp_rx;
        localparam int H = 8;
        @(negedge clk);
        cfg_master = 1'b0; loopback = 1'b0; cfg_frame_len = 5'(len); cfg_lsb_first = lsb;
        cfg_invert = inv; cfg_cpha = cpha; cfg_cpol = cpol; cfg_irq_on_empty = 0;
        sck_in = cpol;
        repeat (6) @(negedge clk);
        chk(sck_oe == 1'b0, "R6 sck_oe in slave", sck_oe, 0);
        tx_data = data; tx_wr = 1'b1;
        @(negedge clk) tx_wr = 1'b0;
        repeat (2) @(negedge clk);
        for (int k = 0; k < len; k++) begin
            if (!cpha) begin
                sdi_drv = sin[k];
                repeat (H) @(negedge clk);
                got[k] = sdo;
                sck_in = ~cpol;
                repeat (H) @(negedge clk);
                sck_in = cpol;
            end else begin
                sck_in = ~cpol;
                repeat (H) @(negedge clk);
                got[k] = sdo;
                sdi_drv = sin[k];
                sck_in = cpol;
            end
            if (cpha) repeat (H) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        mask = 16'((32'd1 << len) - 1);
        exp_rx = seq_word(sin, len, lsb, inv);
        chk(got == wire_seq(data & mask, len, lsb, inv), "R6 slave wire bits (R2 R3 R4)",
            got, wire_seq(data & mask, len, lsb, inv));
        chk(rx_valid && rx_data == exp_rx, "R6 slave received word (R3)", rx_data, exp_rx);
        read_rx();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_master(16'h00A5, 8, 0, 0, 0, 0, 0, 1, 0);
        t_master(16'h1234, 16, 1, 1, 1, 1, 1, 2, 0);
        t_master(16'h005A, 7, 0, 0, 1, 0, 0, 0, 1);
        t_master(16'h0055, 3, 1, 0, 0, 1, 2, 0, 1);
        t_master(16'hBEEF, 20, 0, 1, 0, 0, 0, 2, 0);
        t_overrun();
        t_txbuf();
        t_slave(16'h00C6, 16'h00B1, 8, 0, 0, 0, 0);
        t_slave(16'h02D3, 16'h0176, 10, 1, 1, 1, 1);
        done = 1;
        summary();
    end
endmodule